// File: doc/BRIEF.md
# Loop-Gated Next-Line Data Prefetcher

This controller sits beside a data cache and watches its stream of accesses. When a memory instruction makes the first real use of a cache line, the controller asks memory for the line that follows it. The controller only acts if the instruction that made the access was itself fetched as a guaranteed hit in the small instruction filter cache. The pipeline carries that flag down with each memory instruction. A guaranteed fetch hit indicates that the code is running inside a small, stable loop, which is where sequential data streaming pays off. Accesses from instructions whose fetch was not guaranteed never start a prefetch.

The controller keeps a direct-mapped shadow directory with the same geometry as the data cache. Each shadow entry holds a valid bit, a tag and a first-use marker.
- A line installed by a demand miss starts with the marker clear, because the miss itself is the trigger.
- A line installed by an accepted prefetch starts with the marker set. The marker clears on that line's first demand access, and that access triggers the next line.
- A trigger is dropped when the next line is already recorded as present, or when the current line is the last one in the address space.

A single pending slot holds one request. The slot waits for the cache to report idle before it offers the request downstream. The access port is a snoop and has no back-pressure. The request port is valid/ready: once `pf_valid` is high, `pf_valid` and `pf_addr` hold steady until `pf_ready` is seen.

Top module: `nlp_prefetch_ctl`

## Requirements
- R1: After reset, `pf_valid` is low, and every directory entry is empty.
- R2: A demand miss (`acc_hit`=0) with `acc_fhit`=1 produces a request whose `pf_addr` is the access's line address plus one line (LINE_BYTES). The offset bits of `pf_addr` are zero.
- R3: An access with `acc_fhit`=0 never produces a request. It still installs the line or clears the line's first-use marker, so a later hit on that line with `acc_fhit`=1 produces no request either.
- R4: An accepted request installs its line with the first-use marker set. The first demand hit on that line with `acc_fhit`=1 requests the following line. A second hit on the same line requests nothing.
- R5: A hit on a line that the directory does not hold produces no request.
- R6: No request is made when the next line is recorded as present in the directory.
- R7: A request becomes visible only after a cycle with `cache_idle`=1 that follows the triggering access. While `cache_idle` stays low, `pf_valid` stays low.
- R8: While `pf_valid`=1 and `pf_ready`=0, `pf_valid` and `pf_addr` are held unchanged in the next cycle.
- R9: A new trigger replaces a pending request that is not yet offered. A trigger that arrives while a request is offered (`pf_valid`=1) is dropped.
- R10: An access to the highest line in the address space produces no request, so `pf_addr` never wraps to line zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A data cache access completes this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_hit | input | 1 | 1 = the access hit the data cache, 0 = demand miss and fill |
| acc_fhit | input | 1 | The accessing instruction's fetch was a guaranteed filter-cache hit |
| cache_idle | input | 1 | The data cache has no access in progress |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | The memory side accepts the offered request |
| pf_addr | output | ADDR_W | Line-aligned byte address of the requested line |

## Verification
The embedded properties check the following on every cycle:
- the held request under back-pressure;
- that the request only rises after an idle cycle;
- that the requested line is never line zero;
- that an access always leaves its line's first-use marker clear.

Only the directed scenarios can show the rest:
- the loop-flag gating;
- the chain of triggers through prefetched lines;
- suppression when the next line is present or the top of memory is reached;
- replace-versus-drop in the pending slot.

Each of these needs a particular history of accesses before the outcome is visible at the request port.

// File: rtl/nlp_pkg.sv
package nlp_pkg;

  // State of the single pending prefetch slot.
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_WAIT  = 2'd1,
    SLOT_SEND  = 2'd2
  } slot_st_e;

endpackage

// File: rtl/nlp_line_dir.sv
module nlp_line_dir #(
  parameter int LINE_W = 28,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] a_line,
  output logic              a_hit,
  output logic              a_first,
  input  logic [LINE_W-1:0] b_line,
  output logic              b_hit,
  input  logic              dem_we,
  input  logic [LINE_W-1:0] dem_line,
  input  logic              pf_we,
  input  logic [LINE_W-1:0] pf_line
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = LINE_W - IDX_W;

  logic [SETS-1:0]             vld_q;
  logic [SETS-1:0]             first_q;
  logic [SETS-1:0][TAG_W-1:0]  tag_q;

  logic [IDX_W-1:0] a_idx, b_idx, dem_idx, pf_idx;
  logic [TAG_W-1:0] a_tag, b_tag, dem_tag, pf_tag;

  assign a_idx   = a_line[IDX_W-1:0];
  assign a_tag   = a_line[LINE_W-1:IDX_W];
  assign b_idx   = b_line[IDX_W-1:0];
  assign b_tag   = b_line[LINE_W-1:IDX_W];
  assign dem_idx = dem_line[IDX_W-1:0];
  assign dem_tag = dem_line[LINE_W-1:IDX_W];
  assign pf_idx  = pf_line[IDX_W-1:0];
  assign pf_tag  = pf_line[LINE_W-1:IDX_W];

  // Lookups
  assign a_hit   = vld_q[a_idx] && (tag_q[a_idx] == a_tag);
  assign a_first = first_q[a_idx];
  assign b_hit   = vld_q[b_idx] && (tag_q[b_idx] == b_tag);

  // Demand install or update takes priority over a prefetch install on the same set.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      first_q <= '0;
      tag_q   <= '0;
    end else begin
      for (int i = 0; i < SETS; i++) begin
        if (dem_we && (dem_idx == IDX_W'(i))) begin
          vld_q[i]   <= 1'b1;
          tag_q[i]   <= dem_tag;
          first_q[i] <= 1'b0;
        end else if (pf_we && (pf_idx == IDX_W'(i))) begin
          vld_q[i]   <= 1'b1;
          tag_q[i]   <= pf_tag;
          first_q[i] <= 1'b1;
        end
      end
    end
  end

  // R3/R4: any access leaves its set's first-use marker clear
  assert_first_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dem_we |=> !first_q[$past(dem_idx)]);

endmodule

// File: rtl/nlp_trigger.sv
module nlp_trigger #(
  parameter int LINE_W = 28
) (
  input  logic              acc_valid,
  input  logic              acc_hit,
  input  logic              acc_fhit,
  input  logic [LINE_W-1:0] acc_line,
  input  logic              dir_a_hit,
  input  logic              dir_a_first,
  input  logic              dir_b_hit,
  output logic [LINE_W-1:0] next_line,
  output logic              trig
);
  logic at_top;
  logic first_use;

  assign at_top    = &acc_line;
  assign next_line = acc_line + LINE_W'(1);

  // First real use: a demand miss, or the first hit on a prefetched line.
  assign first_use = acc_valid && (!acc_hit || (dir_a_hit && dir_a_first));
  assign trig      = first_use && acc_fhit && !at_top && !dir_b_hit;

endmodule

// File: rtl/nlp_pend_slot.sv
module nlp_pend_slot
  import nlp_pkg::*;
#(
  parameter int LINE_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [LINE_W-1:0] load_line,
  input  logic              cache_idle,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [LINE_W-1:0] pf_line
);
  slot_st_e          st_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SLOT_EMPTY;
      line_q <= '0;
    end else begin
      unique case (st_q)
        SLOT_EMPTY: if (load_i) begin
          st_q   <= SLOT_WAIT;
          line_q <= load_line;
        end
        SLOT_WAIT: if (load_i) begin
          line_q <= load_line;          // replace unissued request
        end else if (cache_idle) begin
          st_q <= SLOT_SEND;
        end
        SLOT_SEND: if (pf_ready) begin
          st_q <= SLOT_EMPTY;           // triggers while offered are dropped
        end
        default: st_q <= SLOT_EMPTY;
      endcase
    end
  end

  assign pf_valid = (st_q == SLOT_SEND);
  assign pf_line  = line_q;

  // R8: an offered request is held until accepted
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line)));

  // R7: a request only appears after an idle cycle
  assert_idle_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> $past(cache_idle));

endmodule

// File: rtl/nlp_prefetch_ctl.sv
module nlp_prefetch_ctl #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_hit,
  input  logic              acc_fhit,
  input  logic              cache_idle,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int LINE_W = ADDR_W - OFF_W;

  logic [LINE_W-1:0] acc_line, next_line, pf_line;
  logic              a_hit, a_first, b_hit, trig, pf_take;
  logic              unused_off;

  assign acc_line   = acc_addr[ADDR_W-1:OFF_W];
  assign unused_off = ^acc_addr[OFF_W-1:0];
  assign pf_take    = pf_valid && pf_ready;

  nlp_line_dir #(.LINE_W(LINE_W), .IDX_W(IDX_W)) u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_line   (acc_line),
    .a_hit    (a_hit),
    .a_first  (a_first),
    .b_line   (next_line),
    .b_hit    (b_hit),
    .dem_we   (acc_valid),
    .dem_line (acc_line),
    .pf_we    (pf_take),
    .pf_line  (pf_line)
  );

  nlp_trigger #(.LINE_W(LINE_W)) u_trig (
    .acc_valid   (acc_valid),
    .acc_hit     (acc_hit),
    .acc_fhit    (acc_fhit),
    .acc_line    (acc_line),
    .dir_a_hit   (a_hit),
    .dir_a_first (a_first),
    .dir_b_hit   (b_hit),
    .next_line   (next_line),
    .trig        (trig)
  );

  nlp_pend_slot #(.LINE_W(LINE_W)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (trig),
    .load_line  (next_line),
    .cache_idle (cache_idle),
    .pf_ready   (pf_ready),
    .pf_valid   (pf_valid),
    .pf_line    (pf_line)
  );

  assign pf_addr = {pf_line, {OFF_W{1'b0}}};

  // R10: the requested line never wraps to line zero
  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_line != '0));

endmodule

// File: tb/nlp_prefetch_ctl_test.sv
`timescale 1ns/1ps
module nlp_prefetch_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_hit = 1'b0;
  logic        acc_fhit = 1'b0;
  logic        cache_idle = 1'b0;
  logic        pf_valid;
  logic        pf_ready = 1'b0;
  logic [31:0] pf_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  nlp_prefetch_ctl uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_hit(acc_hit), .acc_fhit(acc_fhit), .cache_idle(cache_idle),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic hit, input logic fh);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_hit = hit; acc_fhit = fh; cache_idle = 1'b0;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic expect_pf(input logic [31:0] exp, input string req);
    cache_idle = 1'b1;
    @(negedge clk);
    chk(pf_valid == 1'b1, req, "pf_valid", {31'd0, pf_valid}, 32'd1);
    chk(pf_addr == exp, req, "pf_addr", pf_addr, exp);
    pf_ready = 1'b1;
    @(negedge clk);
    pf_ready = 1'b0;
    chk(pf_valid == 1'b0, req, "pf_valid after accept", {31'd0, pf_valid}, 32'd0);
  endtask

  task automatic expect_none(input string req);
    cache_idle = 1'b1;
    repeat (3) @(negedge clk);
    chk(pf_valid == 1'b0, req, "no request", {31'd0, pf_valid}, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(pf_valid == 1'b0, "R1", "pf_valid at reset", {31'd0, pf_valid}, 32'd0);
    access(32'h0000_3000, 1'b1, 1'b1);   // empty directory: hit is not first use
    expect_none("R1");
  endtask

  task automatic t_miss_trigger;   // R2
    access(32'h0000_1004, 1'b0, 1'b1);
    expect_pf(32'h0000_1010, "R2");
  endtask

  task automatic t_chain;          // R4
    access(32'h0000_1014, 1'b1, 1'b1);
    expect_pf(32'h0000_1020, "R4");
    access(32'h0000_1018, 1'b1, 1'b1);
    expect_none("R4");
  endtask

  task automatic t_flag_gate;      // R3
    access(32'h0000_2000, 1'b0, 1'b0);
    expect_none("R3");
    access(32'h0000_2004, 1'b1, 1'b1);
    expect_none("R3");
  endtask

  task automatic t_present;        // R6
    access(32'h0000_1000, 1'b0, 1'b1);
    expect_none("R6");
  endtask

  task automatic t_unknown_hit;    // R5
    access(32'h0000_3000, 1'b1, 1'b1);
    expect_none("R5");
  endtask

  task automatic t_idle_wait;      // R7
    access(32'h0000_9000, 1'b0, 1'b1);
    repeat (3) begin
      @(negedge clk);
      chk(pf_valid == 1'b0, "R7", "held while busy", {31'd0, pf_valid}, 32'd0);
    end
    expect_pf(32'h0000_9010, "R7");
  endtask

  task automatic t_hold;           // R8
    access(32'h0000_8000, 1'b0, 1'b1);
    cache_idle = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(pf_valid == 1'b1, "R8", "valid held", {31'd0, pf_valid}, 32'd1);
      chk(pf_addr == 32'h0000_8010, "R8", "addr held", pf_addr, 32'h0000_8010);
    end
    expect_pf(32'h0000_8010, "R8");
  endtask

  task automatic t_replace_drop;   // R9
    access(32'h0000_4000, 1'b0, 1'b1);
    access(32'h0000_5000, 1'b0, 1'b1);
    expect_pf(32'h0000_5010, "R9");
    expect_none("R9");
    access(32'h0000_6000, 1'b0, 1'b1);
    cache_idle = 1'b1;
    @(negedge clk);
    chk(pf_valid == 1'b1, "R9", "offered", {31'd0, pf_valid}, 32'd1);
    access(32'h0000_7000, 1'b0, 1'b1);
    chk(pf_addr == 32'h0000_6010, "R9", "offer kept", pf_addr, 32'h0000_6010);
    expect_pf(32'h0000_6010, "R9");
    expect_none("R9");
  endtask

  task automatic t_top;            // R10
    access(32'hFFFF_FFF0, 1'b0, 1'b1);
    expect_none("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_miss_trigger();
    t_chain();
    t_flag_gate();
    t_present();
    t_unknown_hit();
    t_idle_wait();
    t_hold();
    t_replace_drop();
    t_top();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule